// File: doc/BRIEF.md
# Grouped Interrupt Expander with Per-Source Vectors

The block collects a large set of peripheral interrupt requests and folds them onto a small number of CPU interrupt lines. Sources are arranged in groups; each group owns one CPU line. Within a group every source has a latched request flag and an enable bit. A group raises its CPU line once and then holds off until software re-arms it. At the CPU level the block keeps a per-line flag register and a global mask bit. The CPU supplies a per-line enable register.

While a request is presented, the block drives a vector address that points directly at the table entry of the winning source. The interrupt service routine therefore starts in the right place without polling any status. When the CPU accepts the interrupt, the block clears the winning source flag and the CPU line flag and sets the global mask, all on the same clock edge.

A table-select input switches between two tables. One is an expanded table with one two-word entry per source, placed after 32 reserved CPU-level entries. The other is a small fixed boot table with one entry per CPU line. In boot mode the source flags are left untouched on acceptance.

Top module: `irq_group_expander`

## Requirements
- R1: After reset all source flags, CPU line flags and group hold-off latches are clear, the global mask is 1 and `irq_req` is 0.
- R2: A high `periph_irq` bit sets its source flag on the next edge. An enabled flagged source in a group that is not held off sets that group's `cpu_flags` bit (bit g for group g) one edge later. A source whose `src_en` bit is 0 never raises its line, but its flag stays latched and raises the line once enabled.
- R3: `irq_req` is 1 exactly when some `cpu_flags` bit and the matching `cpu_ier` bit are both 1 and `cpu_mask` is 0.
- R4: When several CPU lines are requesting, the lowest-numbered group wins the vector and the acceptance.
- R5: Within a group, the lowest-numbered pending and enabled source wins.
- R6: With `table_sel` = 1, `irq_vector` = 0x000D00 + 2*(32 + 8*g + s), with g the winning group (0..11) and s the winning source (0..7), where input bit `periph_irq[8*g+s]` is source s of group g.
- R7: With `table_sel` = 0, `irq_vector` = 0x3FFFC0 + 2*(g+1). Acceptance then clears the CPU flag and sets the mask, but leaves the source flags unchanged.
- R8: `irq_ack` while `irq_req` is 1 clears the winning source flag and CPU flag bit and sets `cpu_mask` on that one edge. `irq_ack` while `irq_req` is 0 has no effect.
- R9: After raising its line, a group raises it again only after a `grp_rearm` pulse for that group, and only if an enabled source flag is still set.
- R10: A new request on a source in the same cycle as the acceptance that clears that source leaves the flag set.
- R11: `mask_set` sets and `mask_clr` clears `cpu_mask`. An acceptance in the same cycle overrides `mask_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| periph_irq | input | 96 | Peripheral request per source, bit 8*g+s |
| src_en | input | 96 | Per-source enable, same bit layout |
| grp_rearm | input | 12 | Pulse to release a group's hold-off latch |
| cpu_ier | input | 12 | CPU line enable register |
| mask_set | input | 1 | Set the global mask |
| mask_clr | input | 1 | Clear the global mask |
| table_sel | input | 1 | 1: expanded per-source table, 0: boot table |
| irq_ack | input | 1 | CPU accepts the presented interrupt |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vector | output | 22 | Word address of the vector entry |
| cpu_flags | output | 12 | CPU line flag register |
| cpu_mask | output | 1 | Global mask bit |

## Verification
Acceptance and new-request capture can fall in the same cycle. The bench provokes this by pulsing the same source on the edge where `irq_ack` clears it. After re-arming the group, it judges the outcome by whether the CPU line comes back. The same edge can also carry an acceptance together with `mask_clr`; the mask must read 1 afterwards. A full sweep over all 96 sources checks the arithmetic vector for each source. In the same sweep, the line must stay quiet after re-arming, which shows that the flag was consumed.

// File: rtl/irqx_pkg.sv
package irqx_pkg;

    // CPU-level vector slots that precede the per-source entries
    localparam int CPU_SLOTS  = 32;
    // words per vector entry (32-bit entries, 16-bit words)
    localparam int ENTRY_WORDS = 2;

    // Global mask next-state: acceptance dominates, then set, then clear
    function automatic logic mask_next(input logic cur, input logic taken,
                                       input logic set, input logic clr);
        logic n;
        n = cur;
        if (clr)   n = 1'b0;
        if (set)   n = 1'b1;
        if (taken) n = 1'b1;
        return n;
    endfunction

endpackage

// File: rtl/irqx_group.sv
module irqx_group #(
    parameter  int GS = 8,
    localparam int SW = (GS > 1) ? $clog2(GS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [GS-1:0] irq_i,
    input  logic [GS-1:0] en_i,
    input  logic          rearm_i,
    input  logic          take_i,
    output logic          raise_o,
    output logic [SW-1:0] src_idx_o
);

    typedef struct packed {
        logic [GS-1:0] flag;
        logic          held;
    } grp_state_t;

    grp_state_t st_q, st_d;
    logic [GS-1:0] pend;
    logic [GS-1:0] clr_mask;
    logic          any_pend;
    logic [SW-1:0] idx;

    always_comb begin
        pend     = st_q.flag & en_i;
        any_pend = |pend;
        idx      = '0;
        for (int i = GS - 1; i >= 0; i--) begin
            if (pend[i]) idx = SW'(i);
        end
        clr_mask = (take_i && any_pend) ? (GS'(1) << idx) : '0;

        st_d      = st_q;
        st_d.flag = (st_q.flag & ~clr_mask) | irq_i;
        st_d.held = (any_pend && !st_q.held) || (st_q.held && !rearm_i);

        raise_o   = any_pend && !st_q.held;
        src_idx_o = idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/irqx_cpu_stage.sv
module irqx_cpu_stage
    import irqx_pkg::*;
#(
    parameter  int NG        = 12,
    parameter  int GS        = 8,
    parameter  int VAW       = 22,
    parameter  int EXP_BASE  = 'h000D00,
    parameter  int BOOT_BASE = 'h3FFFC0,
    localparam int SW        = (GS > 1) ? $clog2(GS) : 1,
    localparam int GW        = (NG > 1) ? $clog2(NG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NG-1:0]    raise_i,
    input  logic [NG*SW-1:0] src_idx_i,
    input  logic [NG-1:0]    ier_i,
    input  logic             ack_i,
    input  logic             mask_set_i,
    input  logic             mask_clr_i,
    input  logic             table_sel_i,
    output logic             req_o,
    output logic [VAW-1:0]   vector_o,
    output logic [NG-1:0]    take_o,
    output logic [NG-1:0]    ifr_o,
    output logic             mask_o
);

    typedef struct packed {
        logic [NG-1:0] ifr;
        logic          mask;
    } cpu_state_t;

    cpu_state_t st_q, st_d;
    logic [NG-1:0] active;
    logic [NG-1:0] take_1h;
    logic [GW-1:0] sel_g;
    logic [SW-1:0] sel_s;
    logic          req;
    logic          taken;
    int            slot;

    always_comb begin
        active = st_q.ifr & ier_i;
        sel_g  = '0;
        for (int i = NG - 1; i >= 0; i--) begin
            if (active[i]) sel_g = GW'(i);
        end
        sel_s   = src_idx_i[sel_g*SW +: SW];
        req     = (|active) && !st_q.mask;
        taken   = ack_i && req;
        take_1h = taken ? (NG'(1) << sel_g) : '0;

        slot = CPU_SLOTS + int'(sel_g) * GS + int'(sel_s);
        if (table_sel_i) vector_o = VAW'(EXP_BASE + ENTRY_WORDS * slot);
        else             vector_o = VAW'(BOOT_BASE + ENTRY_WORDS * (int'(sel_g) + 1));

        st_d      = st_q;
        st_d.ifr  = (st_q.ifr & ~take_1h) | raise_i;
        st_d.mask = mask_next(st_q.mask, taken, mask_set_i, mask_clr_i);

        take_o = table_sel_i ? take_1h : '0;
        req_o  = req;
        ifr_o  = st_q.ifr;
        mask_o = st_q.mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ifr  <= '0;
            st_q.mask <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/irq_group_expander.sv
module irq_group_expander #(
    parameter  int NG        = 12,
    parameter  int GS        = 8,
    parameter  int VAW       = 22,
    parameter  int EXP_BASE  = 'h000D00,
    parameter  int BOOT_BASE = 'h3FFFC0,
    localparam int NSRC      = NG * GS,
    localparam int SW        = (GS > 1) ? $clog2(GS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] periph_irq,
    input  logic [NSRC-1:0] src_en,
    input  logic [NG-1:0]   grp_rearm,
    input  logic [NG-1:0]   cpu_ier,
    input  logic            mask_set,
    input  logic            mask_clr,
    input  logic            table_sel,
    input  logic            irq_ack,
    output logic            irq_req,
    output logic [VAW-1:0]  irq_vector,
    output logic [NG-1:0]   cpu_flags,
    output logic            cpu_mask
);

    logic [NG-1:0]    raise;
    logic [NG-1:0]    take;
    logic [NG*SW-1:0] src_idx;

    for (genvar g = 0; g < NG; g++) begin : g_grp
        irqx_group #(.GS(GS)) u_grp (
            .clk       (clk),
            .rst_n     (rst_n),
            .irq_i     (periph_irq[g*GS +: GS]),
            .en_i      (src_en[g*GS +: GS]),
            .rearm_i   (grp_rearm[g]),
            .take_i    (take[g]),
            .raise_o   (raise[g]),
            .src_idx_o (src_idx[g*SW +: SW])
        );
    end

    irqx_cpu_stage #(
        .NG(NG), .GS(GS), .VAW(VAW),
        .EXP_BASE(EXP_BASE), .BOOT_BASE(BOOT_BASE)
    ) u_cpu (
        .clk         (clk),
        .rst_n       (rst_n),
        .raise_i     (raise),
        .src_idx_i   (src_idx),
        .ier_i       (cpu_ier),
        .ack_i       (irq_ack),
        .mask_set_i  (mask_set),
        .mask_clr_i  (mask_clr),
        .table_sel_i (table_sel),
        .req_o       (irq_req),
        .vector_o    (irq_vector),
        .take_o      (take),
        .ifr_o       (cpu_flags),
        .mask_o      (cpu_mask)
    );

endmodule

// File: rtl/irq_group_expander_chk.sv
module irq_group_expander_chk #(
    parameter int NG        = 12,
    parameter int GS        = 8,
    parameter int VAW       = 22,
    parameter int EXP_BASE  = 'h000D00,
    parameter int BOOT_BASE = 'h3FFFC0
) (
    input logic           clk,
    input logic           rst_n,
    input logic           irq_req,
    input logic           irq_ack,
    input logic           mask_set,
    input logic           mask_clr,
    input logic           table_sel,
    input logic [NG-1:0]  cpu_ier,
    input logic [NG-1:0]  cpu_flags,
    input logic           cpu_mask,
    input logic [VAW-1:0] irq_vector
);

    // R3
    req_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ((|(cpu_flags & cpu_ier)) && !cpu_mask));

    // R8
    ack_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req) |=> (cpu_mask && !irq_req));

    // R8
    idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !irq_req && !mask_set && !mask_clr) |=> $stable(cpu_mask));

    // R11
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_clr && !mask_set && !(irq_ack && irq_req)) |=> !cpu_mask);

    // R6
    exp_vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && table_sel) |->
            (!irq_vector[0] && int'(irq_vector) >= EXP_BASE + 64
             && int'(irq_vector) < EXP_BASE + 64 + 2 * NG * GS));

    // R7
    boot_vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !table_sel) |->
            (int'(irq_vector) > BOOT_BASE && int'(irq_vector) <= BOOT_BASE + 2 * NG));

endmodule

bind irq_group_expander irq_group_expander_chk #(
    .NG(NG), .GS(GS), .VAW(VAW), .EXP_BASE(EXP_BASE), .BOOT_BASE(BOOT_BASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_req    (irq_req),
    .irq_ack    (irq_ack),
    .mask_set   (mask_set),
    .mask_clr   (mask_clr),
    .table_sel  (table_sel),
    .cpu_ier    (cpu_ier),
    .cpu_flags  (cpu_flags),
    .cpu_mask   (cpu_mask),
    .irq_vector (irq_vector)
);

// File: tb/irq_group_expander_bench.sv
`timescale 1ns/1ps
module irq_group_expander_bench;

    localparam int NG = 12;
    localparam int GS = 8;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NG*GS-1:0] periph_irq;
    logic [NG*GS-1:0] src_en;
    logic [NG-1:0]   grp_rearm;
    logic [NG-1:0]   cpu_ier;
    logic            mask_set, mask_clr, table_sel, irq_ack;
    logic            irq_req;
    logic [21:0]     irq_vector;
    logic [NG-1:0]   cpu_flags;
    logic            cpu_mask;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    irq_group_expander u_irq_group_expander (
        .clk(clk), .rst_n(rst_n), .periph_irq(periph_irq), .src_en(src_en),
        .grp_rearm(grp_rearm), .cpu_ier(cpu_ier), .mask_set(mask_set),
        .mask_clr(mask_clr), .table_sel(table_sel), .irq_ack(irq_ack),
        .irq_req(irq_req), .irq_vector(irq_vector), .cpu_flags(cpu_flags),
        .cpu_mask(cpu_mask)
    );

    function automatic int exp_vec(int g, int s);
        return 'hD00 + 2 * (32 + 8 * g + s);
    endfunction

    function automatic int boot_vec(int g);
        return 'h3FFFC0 + 2 * (g + 1);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 0; periph_irq = '0; src_en = '1; grp_rearm = '0; cpu_ier = '1;
        mask_set = 0; mask_clr = 0; table_sel = 1; irq_ack = 0;
        tick(); tick();
        rst_n = 1;
        tick();
    endtask

    task automatic pulse_src(int g, int s);
        periph_irq[g*GS+s] = 1'b1; tick(); periph_irq = '0;
    endtask

    task automatic unmask();
        mask_clr = 1; tick(); mask_clr = 0;
    endtask

    task automatic accept();
        irq_ack = 1; tick(); irq_ack = 0;
    endtask

    task automatic rearm(int g);
        grp_rearm[g] = 1'b1; tick(); grp_rearm = '0; tick();
    endtask

    initial begin
        do_reset();
        // R1 reset state
        chk(cpu_flags == 0, "R1 flags", cpu_flags, 0);
        chk(cpu_mask == 1, "R1 mask", cpu_mask, 1);
        chk(irq_req == 0, "R1 req", irq_req, 0);

        // Sweep all sources: R2, R3, R6, R8, R9
        for (int g = 0; g < NG; g++) begin
            for (int s = 0; s < GS; s++) begin
                pulse_src(g, s); tick();
                chk(cpu_flags == (NG'(1) << g), "R2 raise", cpu_flags, NG'(1) << g);
                chk(irq_req == 0, "R3 masked", irq_req, 0);
                unmask();
                chk(irq_req == 1, "R3 request", irq_req, 1);
                chk(int'(irq_vector) == exp_vec(g, s), "R6 vector", irq_vector, exp_vec(g, s));
                accept();
                chk(cpu_flags == 0, "R8 flag clear", cpu_flags, 0);
                chk(cpu_mask == 1, "R8 mask set", cpu_mask, 1);
                rearm(g); tick();
                chk(cpu_flags == 0, "R9 consumed no reraise", cpu_flags, 0);
            end
        end

        // R9 hold-off until rearm
        do_reset();
        pulse_src(3, 2); tick(); unmask(); accept();
        pulse_src(3, 2); tick(); tick();
        chk(cpu_flags == 0, "R9 held off", cpu_flags, 0);
        rearm(3);
        chk(cpu_flags == NG'(1 << 3), "R9 reraise", cpu_flags, 1 << 3);

        // R5 in-group priority
        do_reset();
        periph_irq[1*GS+5] = 1; periph_irq[1*GS+2] = 1; tick(); periph_irq = '0; tick();
        unmask();
        chk(int'(irq_vector) == exp_vec(1, 2), "R5 low src first", irq_vector, exp_vec(1, 2));
        accept(); rearm(1); unmask();
        chk(int'(irq_vector) == exp_vec(1, 5), "R5 next src", irq_vector, exp_vec(1, 5));

        // R4 cross-group priority
        do_reset();
        periph_irq[7*GS+0] = 1; periph_irq[2*GS+4] = 1; tick(); periph_irq = '0; tick();
        unmask();
        chk(int'(irq_vector) == exp_vec(2, 4), "R4 low group first", irq_vector, exp_vec(2, 4));
        accept(); unmask();
        chk(int'(irq_vector) == exp_vec(7, 0), "R4 next group", irq_vector, exp_vec(7, 0));

        // R2 disabled source latched but silent
        do_reset();
        src_en[0] = 0;
        pulse_src(0, 0); tick(); tick();
        chk(cpu_flags == 0, "R2 disabled silent", cpu_flags, 0);
        src_en[0] = 1; tick(); tick();
        chk(cpu_flags == NG'(1), "R2 latched raises on enable", cpu_flags, 1);

        // R3 line enable gates request
        cpu_ier = '0; unmask();
        chk(irq_req == 0, "R3 ier off", irq_req, 0);
        cpu_ier = '1; tick();
        chk(irq_req == 1, "R3 ier on", irq_req, 1);

        // R7 boot table
        do_reset();
        table_sel = 0;
        pulse_src(4, 3); tick(); unmask();
        chk(int'(irq_vector) == boot_vec(4), "R7 boot vector", irq_vector, boot_vec(4));
        accept();
        chk(cpu_flags == 0 && cpu_mask == 1, "R7 boot accept", {cpu_flags, cpu_mask}, 1);
        table_sel = 1; rearm(4);
        chk(cpu_flags == NG'(1 << 4), "R7 source flag kept", cpu_flags, 1 << 4);
        unmask();
        chk(int'(irq_vector) == exp_vec(4, 3), "R7 then expanded", irq_vector, exp_vec(4, 3));

        // R8 ack with no request ignored
        do_reset();
        unmask(); accept();
        chk(cpu_mask == 0, "R8 idle ack ignored", cpu_mask, 0);

        // R10 new request on acceptance edge survives
        do_reset();
        pulse_src(0, 1); tick(); unmask();
        periph_irq[1] = 1; irq_ack = 1; tick(); periph_irq = '0; irq_ack = 0;
        chk(cpu_flags == 0 && cpu_mask == 1, "R10 accept", {cpu_flags, cpu_mask}, 1);
        rearm(0);
        chk(cpu_flags == NG'(1), "R10 flag survived", cpu_flags, 1);

        // R11 mask set, and acceptance overrides clear
        do_reset();
        unmask();
        mask_set = 1; tick(); mask_set = 0;
        chk(cpu_mask == 1, "R11 mask set", cpu_mask, 1);
        pulse_src(6, 0); tick(); unmask();
        mask_clr = 1; irq_ack = 1; tick(); mask_clr = 0; irq_ack = 0;
        chk(cpu_mask == 1, "R11 accept beats clear", cpu_mask, 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule